// File: doc/BRIEF.md
# Cache-Line SEC-DED Error-Correcting Code Unit

This block guards a 256-bit cache line with 10 check bits. The writer of the line passes the data word through the encode path and stores the check bits next to it. The reader of the line passes every stored data word and check word through the decode path. The decode path corrects any single flipped bit and flags any double flip as uncorrectable, without changing the data. It also reports a clean read when it finds no error.

The code is a Hsiao-style single-error-correcting, double-error-detecting code. Every data bit feeds an odd number of check bits, either three or five, and every check bit covers the same number of data bits. A check bit's own column in the parity matrix is a unit vector. Because every column has odd weight, any double error gives a nonzero syndrome of even weight. A syndrome like that can never be mistaken for a single error.

Both paths are fully combinational up to one output register stage. Each path accepts a new word on every clock.

Top module: `ecc_line_codec`

## Requirements
- R1: `enc_out_valid` rises exactly one cycle after `enc_valid` and is low one cycle after a cycle with `enc_valid` low. The check word for an all-zero data word is all zero.
- R2: The check word produced for a data word holding a single one (its column) has three or five bits set. The 256 columns are distinct, and exactly 120 of them have three bits set.
- R3: Each of the 10 check bits depends on exactly 104 of the data bits. Encoding is linear: the check word of `a ^ b` equals the XOR of the check words of `a` and `b`.
- R4: `dec_out_valid` is high exactly one cycle after each cycle with `dec_valid` high, and low otherwise.
- R5: A word whose check bits match its data reports clean (flags `{dec_clean,dec_fixed,dec_uncorr}` = 3'b100), a zero syndrome, and unchanged data.
- R6: A word with one flipped data bit reports fixed (3'b010) and restores the original data. Its syndrome equals the column of the flipped bit.
- R7: A word with one flipped check bit j reports fixed (3'b010) and leaves the data unchanged. Its syndrome has only bit j set.
- R8: A word with any two flipped bits, in data or check, reports uncorrectable (3'b001). The data is passed through exactly as received, and the syndrome is the XOR of the two columns.
- R9: An odd-weight syndrome that matches no column (weight 7 or 9) reports uncorrectable (3'b001), with the data passed through unchanged.
- R10: Synchronous active-high reset clears both output valids, and every valid decode output asserts exactly one of the three status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid | input | 1 | Encode request |
| enc_data | input | 256 | Data word to encode |
| enc_out_valid | output | 1 | Encode result valid |
| enc_check_out | output | 10 | Computed check word |
| dec_valid | input | 1 | Decode request |
| dec_data | input | 256 | Stored data word |
| dec_check | input | 10 | Stored check word |
| dec_out_valid | output | 1 | Decode result valid |
| dec_data_out | output | 256 | Corrected or passed-through data |
| dec_clean | output | 1 | No error found |
| dec_fixed | output | 1 | Single error corrected |
| dec_uncorr | output | 1 | Uncorrectable error |
| dec_syndrome | output | 10 | Syndrome of the decoded word |

## Verification
Both paths register their results once, so each result is due on the first rising edge after the cycle its request was driven. The bench drives requests on falling edges. Its monitor samples 2 ns after every rising edge. On each sample the monitor expects a decode result exactly when the previous falling edge pushed one into the scoreboard queue, and it flags an output that comes early, late or without a request. The encode path is read at the same point after each request, and its columns then serve as the model for building single-, double- and odd-weight error cases.

// File: rtl/ecc_line_pkg.sv
`timescale 1ns/1ps
package ecc_line_pkg;
  localparam int DATA_W  = 256;
  localparam int CHK_W   = 10;
  localparam int N_CODE  = DATA_W + CHK_W;
  localparam int N_W3    = CHK_W * (CHK_W - 1) * (CHK_W - 2) / 6;
  localparam int N_W5    = DATA_W - N_W3;
  localparam int N_ORB   = (N_W5 - 6) / CHK_W;
  localparam int SYM_V   = 1 << CHK_W;

  typedef logic [CHK_W-1:0] col_t;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_UNCORR = 2'd2
  } dec_status_e;

  function automatic int pop(input col_t v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic col_t rotl(input col_t v, input int n);
    col_t r;
    r = v;
    for (int k = 0; k < n; k++) r = {r[CHK_W-2:0], r[CHK_W-1]};
    return r;
  endfunction

  function automatic col_t even_mask();
    col_t m;
    m = '0;
    for (int b = 0; b < CHK_W; b += 2) m[b] = 1'b1;
    return m;
  endfunction

  // smallest member of its rotation class
  function automatic bit is_rep(input col_t v);
    for (int n = 1; n < CHK_W; n++)
      if (rotl(v, n) < v) return 1'b0;
    return 1'b1;
  endfunction

  function automatic col_t nth_w3(input int idx);
    int cnt;
    cnt = 0;
    for (int v = 0; v < SYM_V; v++) begin
      if (pop(col_t'(v)) == 3) begin
        if (cnt == idx) return col_t'(v);
        cnt++;
      end
    end
    return '0;
  endfunction

  // weight-5 rotation classes of full length, skipping the alternating pair
  function automatic col_t nth_rep5(input int idx);
    int cnt;
    cnt = 0;
    for (int v = 0; v < SYM_V; v++) begin
      if (pop(col_t'(v)) == 5 && is_rep(col_t'(v)) && col_t'(v) != even_mask()) begin
        if (cnt == idx) return col_t'(v);
        cnt++;
      end
    end
    return '0;
  endfunction

  // first unused class with 3 even-position ones after optional rotation
  function automatic col_t side_rep();
    col_t r;
    int   e;
    for (int k = N_ORB; k < N_ORB + 20; k++) begin
      r = nth_rep5(k);
      e = pop(r & even_mask());
      if (e == 3) return r;
      if (e == 2) return rotl(r, 1);
    end
    return '0;
  endfunction

  // parity-matrix column of code position idx (data first, then check bits)
  function automatic col_t col_of(input int idx);
    int k;
    if (idx >= DATA_W) return col_t'(1) << (idx - DATA_W);
    if (idx < N_W3) return nth_w3(idx);
    k = idx - N_W3;
    if (k < N_ORB * CHK_W) return rotl(nth_rep5(k / CHK_W), k % CHK_W);
    k = k - N_ORB * CHK_W;
    if (k < 5) return rotl(side_rep(), 2 * k);
    return ~even_mask();
  endfunction
endpackage

// File: rtl/ecc_line_enc.sv
`timescale 1ns/1ps
module ecc_line_enc
  import ecc_line_pkg::*;
#(
  parameter int DATA_W = ecc_line_pkg::DATA_W,
  parameter int CHK_W  = ecc_line_pkg::CHK_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  logic [CHK_W-1:0] contrib [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = CHK_W'(col_of(i));
    assign contrib[i] = data[i] ? COL : '0;
  end

  always_comb begin
    check = '0;
    for (int i = 0; i < DATA_W; i++) check ^= contrib[i];
  end
endmodule

// File: rtl/ecc_line_classify.sv
`timescale 1ns/1ps
module ecc_line_classify
  import ecc_line_pkg::*;
#(
  parameter int DATA_W = ecc_line_pkg::DATA_W,
  parameter int CHK_W  = ecc_line_pkg::CHK_W
) (
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] data_flip,
  output dec_status_e       status
);
  logic chk_hit;
  logic any_hit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [CHK_W-1:0] COL = CHK_W'(col_of(i));
    assign data_flip[i] = (syn == COL);
  end

  assign chk_hit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign any_hit = (|data_flip) | chk_hit;

  always_comb begin
    if (syn == '0)   status = ST_CLEAN;
    else if (any_hit) status = ST_FIXED;
    else              status = ST_UNCORR;
  end
endmodule

// File: rtl/ecc_line_codec.sv
`timescale 1ns/1ps
module ecc_line_codec
  import ecc_line_pkg::*;
#(
  parameter int DATA_W = ecc_line_pkg::DATA_W,
  parameter int CHK_W  = ecc_line_pkg::CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid,
  input  logic [DATA_W-1:0] enc_data,
  output logic              enc_out_valid,
  output logic [CHK_W-1:0]  enc_check_out,
  input  logic              dec_valid,
  input  logic [DATA_W-1:0] dec_data,
  input  logic [CHK_W-1:0]  dec_check,
  output logic              dec_out_valid,
  output logic [DATA_W-1:0] dec_data_out,
  output logic              dec_clean,
  output logic              dec_fixed,
  output logic              dec_uncorr,
  output logic [CHK_W-1:0]  dec_syndrome
);
  logic [CHK_W-1:0]  enc_check_c;
  logic [CHK_W-1:0]  recomp_c;
  logic [CHK_W-1:0]  syn_c;
  logic [DATA_W-1:0] flip_c;
  dec_status_e       status_c;

  ecc_line_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data  (enc_data),
    .check (enc_check_c)
  );

  ecc_line_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recomp (
    .data  (dec_data),
    .check (recomp_c)
  );

  assign syn_c = recomp_c ^ dec_check;

  ecc_line_classify #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_class (
    .syn       (syn_c),
    .data_flip (flip_c),
    .status    (status_c)
  );

  // control registers: reset
  always_ff @(posedge clk) begin
    if (rst) begin
      enc_out_valid <= 1'b0;
      dec_out_valid <= 1'b0;
      dec_clean     <= 1'b0;
      dec_fixed     <= 1'b0;
      dec_uncorr    <= 1'b0;
    end else begin
      enc_out_valid <= enc_valid;
      dec_out_valid <= dec_valid;
      dec_clean     <= dec_valid && (status_c == ST_CLEAN);
      dec_fixed     <= dec_valid && (status_c == ST_FIXED);
      dec_uncorr    <= dec_valid && (status_c == ST_UNCORR);
    end
  end

  // wide payload registers: no reset
  always_ff @(posedge clk) begin
    if (enc_valid) enc_check_out <= enc_check_c;
    if (dec_valid) begin
      dec_data_out <= (status_c == ST_FIXED) ? (dec_data ^ flip_c) : dec_data;
      dec_syndrome <= syn_c;
    end
  end

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    enc_valid |=> enc_out_valid); // R1
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enc_valid |=> !enc_out_valid); // R1
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> dec_out_valid); // R4
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> !dec_out_valid); // R4
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && dec_clean |-> dec_data_out == $past(dec_data) && dec_syndrome == '0); // R5
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && dec_fixed |-> $countones(dec_data_out ^ $past(dec_data)) <= 1); // R6
  AST_EVEN_SYN_UNCORR: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && dec_syndrome != '0 && !(^dec_syndrome) |-> dec_uncorr); // R8
  AST_UNCORR_PASS: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && dec_uncorr |-> dec_data_out == $past(dec_data)); // R9
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid |-> $countones({dec_clean, dec_fixed, dec_uncorr}) == 1); // R10
endmodule

// File: tb/ecc_line_codec_tb_top.sv
`timescale 1ns/1ps
module ecc_line_codec_tb_top;
  localparam int DW = 256;
  localparam int CW = 10;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [CW-1:0] syn;
    logic [2:0]    flags;
    logic [7:0]    req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enc_valid = 1'b0;
  logic [DW-1:0] enc_data = '0;
  logic          enc_out_valid;
  logic [CW-1:0] enc_check_out;
  logic          dec_valid = 1'b0;
  logic [DW-1:0] dec_data = '0;
  logic [CW-1:0] dec_check = '0;
  logic          dec_out_valid;
  logic [DW-1:0] dec_data_out;
  logic          dec_clean, dec_fixed, dec_uncorr;
  logic [CW-1:0] dec_syndrome;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [CW-1:0] col [DW];

  always #4 clk = ~clk;

  ecc_line_codec dut_i (
    .clk(clk), .rst(rst),
    .enc_valid(enc_valid), .enc_data(enc_data),
    .enc_out_valid(enc_out_valid), .enc_check_out(enc_check_out),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_check(dec_check),
    .dec_out_valid(dec_out_valid), .dec_data_out(dec_data_out),
    .dec_clean(dec_clean), .dec_fixed(dec_fixed), .dec_uncorr(dec_uncorr),
    .dec_syndrome(dec_syndrome)
  );

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] w;
    for (int k = 0; k < DW / 32; k++) w[k*32 +: 32] = $urandom();
    return w;
  endfunction

  function automatic logic [CW-1:0] chk_of(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= col[i];
    return c;
  endfunction

  function automatic logic [CW-1:0] pos_col(input int p);
    if (p < DW) return col[p];
    return CW'(1) << (p - DW);
  endfunction

  task automatic note(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic do_enc(input logic [DW-1:0] d, output logic [CW-1:0] c);
    @(negedge clk);
    enc_valid = 1'b1;
    enc_data  = d;
    @(posedge clk);
    #2;
    c = enc_check_out;
    if (!enc_out_valid) begin
      checks++; fails++;
      $display("FAIL R1 enc_out_valid actual 0 expected 1");
    end
  endtask

  task automatic dec_push(input logic [DW-1:0] d, input logic [CW-1:0] c,
                          input logic [DW-1:0] ed, input logic [CW-1:0] es,
                          input logic [2:0] ef, input logic [7:0] req);
    exp_t it;
    @(negedge clk);
    dec_valid = 1'b1;
    dec_data  = d;
    dec_check = c;
    it.data = ed; it.syn = es; it.flags = ef; it.req = req;
    q.push_back(it);
  endtask

  // scoreboard monitor (latency R4, content R5..R10)
  initial begin
    exp_t it;
    logic [2:0] got;
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (dec_out_valid) begin
          if (q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 output valid with no pending request: actual 1 expected 0");
          end else begin
            it  = q.pop_front();
            got = {dec_clean, dec_fixed, dec_uncorr};
            checks++;
            if (got != it.flags || dec_syndrome != it.syn || dec_data_out != it.data) begin
              fails++;
              $display("FAIL R%0d flags %b syn %h data %h expected flags %b syn %h data %h",
                       it.req, got, dec_syndrome, dec_data_out, it.flags, it.syn, it.data);
            end
          end
        end else if (q.size() != 0) begin
          it = q.pop_front();
          checks++; fails++;
          $display("FAIL R4 output valid actual 0 expected 1 for request of R%0d", it.req);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] c, ca, cb, s;
    logic [DW-1:0] d, a, b, fd;
    int w3, dups;
    int rowc [CW];

    repeat (3) @(posedge clk);
    #2;
    note(enc_out_valid == 1'b0 && dec_out_valid == 1'b0,
         $sformatf("R10 reset valids actual %b%b expected 00", enc_out_valid, dec_out_valid));
    @(negedge clk);
    rst = 1'b0;

    // R1 zero word
    do_enc('0, c);
    note(c == '0, $sformatf("R1 zero-word check actual %h expected 000", c));

    // R2 learn columns
    w3 = 0;
    for (int i = 0; i < DW; i++) begin
      do_enc(DW'(1) << i, col[i]);
      note($countones(col[i]) == 3 || $countones(col[i]) == 5,
           $sformatf("R2 column %0d weight actual %0d expected 3 or 5", i, $countones(col[i])));
      if ($countones(col[i]) == 3) w3++;
    end
    @(negedge clk);
    enc_valid = 1'b0;
    @(posedge clk);
    #2;
    note(enc_out_valid == 1'b0, $sformatf("R1 idle enc_out_valid actual %b expected 0", enc_out_valid));
    note(w3 == 120, $sformatf("R2 weight-3 columns actual %0d expected 120", w3));
    dups = 0;
    for (int i = 0; i < DW; i++)
      for (int j = i + 1; j < DW; j++)
        if (col[i] == col[j]) dups++;
    note(dups == 0, $sformatf("R2 duplicate columns actual %0d expected 0", dups));

    // R3 row weights and linearity
    for (int r = 0; r < CW; r++) begin
      rowc[r] = 0;
      for (int i = 0; i < DW; i++) rowc[r] += int'(col[i][r]);
      note(rowc[r] == 104, $sformatf("R3 check bit %0d coverage actual %0d expected 104", r, rowc[r]));
    end
    for (int t = 0; t < 6; t++) begin
      a = rand_word(); b = rand_word();
      do_enc(a, ca);
      do_enc(b, cb);
      do_enc(a ^ b, c);
      note(c == (ca ^ cb), $sformatf("R3 linearity actual %h expected %h", c, ca ^ cb));
      note(ca == chk_of(a), $sformatf("R3 column model actual %h expected %h", ca, chk_of(a)));
    end
    @(negedge clk);
    enc_valid = 1'b0;

    // R5 clean words
    dec_push('0, '0, '0, '0, 3'b100, 8'd5);
    dec_push('1, chk_of('1), '1, '0, 3'b100, 8'd5);
    for (int t = 0; t < 8; t++) begin
      d = rand_word();
      dec_push(d, chk_of(d), d, '0, 3'b100, 8'd5);
    end

    // R6 every single data-bit error
    for (int i = 0; i < DW; i++) begin
      d  = rand_word();
      fd = d ^ (DW'(1) << i);
      dec_push(fd, chk_of(d), d, col[i], 3'b010, 8'd6);
    end

    // R7 every single check-bit error
    for (int j = 0; j < CW; j++) begin
      d = rand_word();
      s = CW'(1) << j;
      dec_push(d, chk_of(d) ^ s, d, s, 3'b010, 8'd7);
    end

    // R8 random double errors over all 266 positions
    for (int t = 0; t < 400; t++) begin
      int p, r;
      p = int'($urandom_range(DW + CW - 1));
      r = int'($urandom_range(DW + CW - 2));
      if (r >= p) r++;
      d  = rand_word();
      fd = d;
      c  = chk_of(d);
      if (p < DW) fd[p] = ~fd[p]; else c[p-DW] = ~c[p-DW];
      if (r < DW) fd[r] = ~fd[r]; else c[r-DW] = ~c[r-DW];
      dec_push(fd, c, fd, pos_col(p) ^ pos_col(r), 3'b001, 8'd8);
    end

    // R9 odd syndromes of weight 7 and 9
    for (int k = 0; k < CW; k++) begin
      d = rand_word();
      s = {s[CW-1:0]};
      s = CW'(10'h07F);
      for (int n = 0; n < k; n++) s = {s[CW-2:0], s[CW-1]};
      dec_push(d, chk_of(d) ^ s, d, s, 3'b001, 8'd9);
      s = CW'(10'h1FF);
      for (int n = 0; n < k; n++) s = {s[CW-2:0], s[CW-1]};
      dec_push(d, chk_of(d) ^ s, d, s, 3'b001, 8'd9);
    end

    @(negedge clk);
    dec_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    note(dec_out_valid == 1'b0 && q.size() == 0,
         $sformatf("R4 idle dec_out_valid actual %b expected 0", dec_out_valid));

    // R10 reset mid-stream clears valids
    dec_push('0, '0, '0, '0, 3'b100, 8'd10);
    @(negedge clk);
    dec_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    note(dec_out_valid == 1'b0 && enc_out_valid == 1'b0,
         $sformatf("R10 valids in reset actual %b%b expected 00", enc_out_valid, dec_out_valid));
    @(negedge clk);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule